// File: doc/BRIEF.md
# Miss-Window Load Tracking Buffer

This block records the loads a core executes while a long-latency cache miss is outstanding, so that memory-order hazards against older stores that complete later can still be caught. A load is placed into a set-associative array by indexed insertion: its line address selects one set, and the rest of the line address becomes the tag held next to an age identifier. Completed stores look up the one set their own line address selects. If that set holds the same line with an age younger than the store's, the block raises one violation flag that asks for a rollback to the last checkpoint. The store is never compared against every entry.

The buffer does not keep the program order of the loads and cannot name the load that was hit. A load that finds its line already present merges into that entry and keeps the younger of the two ages. A load whose set is full of other lines raises an overflow flag, which also asks for a rollback, so no load is ever lost. A new line goes to a way picked round-robin among the invalid ways of its set. One cycle of the clear input, or the end of the miss window, empties every entry at once.

The controller has four states. IDLE (empty, no miss): `miss_mode` high moves it to TRACK. TRACK (recording): `miss_mode` low returns it to IDLE and invalidates all entries. A violation event from IDLE or TRACK moves it to VIOLATED. An overflow event from IDLE or TRACK moves it to OVERFLOWED. VIOLATED and OVERFLOWED hold until `clear`. `clear` moves every state to IDLE.

Top module: `unordered_load_buffer`

## Requirements
- R1: After reset, `violation`, `overflow` and `rollback_req` are low and no entry is valid.
- R2: The line address is the address with its low LINE_OFF_W bits removed. Its low log2(SETS) bits select the set, and the remaining upper bits are the tag. Addresses that differ only in the offset bits match the same entry. Lines that share a set but have different tags never match.
- R3: While `miss_mode` is low in IDLE or TRACK, loads are not recorded and stores raise no flag.
- R4: A store accepted with `miss_mode` high, no flag pending and `clear` low raises `violation` and `rollback_req` from the next cycle if its line is recorded with a younger age. A load age L is younger than a store age S when d = (L - S) mod 2^AGE_W is nonzero and below 2^(AGE_W-1). An equal or older age raises nothing.
- R5: A load and a store accepted in the same cycle for the same line are compared with each other as well, under the R4 age rule.
- R6: A load to a line already recorded takes no extra way, and the entry keeps the younger of the stored age and the new age.
- R7: An accepted load whose set holds WAYS valid entries of other lines raises `overflow` and `rollback_req` from the next cycle.
- R8: When a violation and an overflow arise in the same cycle, only `violation` is raised. `violation` and `overflow` are never high together.
- R9: `violation` and `overflow` stay high until `clear`, whatever `miss_mode`, loads and stores do. Loads and stores are ignored while a flag is high.
- R10: `clear` drops all flags and invalidates all entries in the next cycle, and it overrides any load or store in the same cycle.
- R11: `miss_mode` falling while in TRACK invalidates all entries, so later stores do not hit earlier loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_mode | input | 1 | High while a long-latency miss is outstanding |
| clear | input | 1 | Invalidate all entries and drop flags (miss return or checkpoint restore) |
| ld_valid | input | 1 | Load insert request |
| ld_addr | input | ADDR_W | Load byte address |
| ld_age | input | AGE_W | Load age identifier |
| st_valid | input | 1 | Completed-store snoop request |
| st_addr | input | ADDR_W | Store byte address |
| st_age | input | AGE_W | Store age identifier |
| violation | output | 1 | Sticky read-after-write conflict flag |
| overflow | output | 1 | Sticky set-full flag |
| rollback_req | output | 1 | Restart from checkpoint requested |

## Verification
A wrong tag, set index or age in the array shows at the ports only when a later store snoops that set. It appears as a missing or spurious `violation` one cycle after that store. A bad valid bit or a lost invalidation shows up the same way, as stale hits after `clear` or after the miss window ends, or as an early or missing `overflow` on the load that fills a set. A wrong controller state shows up within one cycle as a flag that fails to hold or fails to drop. The bench therefore sweeps every pair of load and store ages in a small configuration and fills every set to its limit.

// File: rtl/lb_pkg.sv
package lb_pkg;
    typedef enum logic [1:0] {
        LB_IDLE       = 2'd0,
        LB_TRACK      = 2'd1,
        LB_VIOLATED   = 2'd2,
        LB_OVERFLOWED = 2'd3
    } lb_state_e;
endpackage

// File: rtl/lb_ctrl.sv
module lb_ctrl
    import lb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic miss_mode,
    input  logic clear,
    input  logic viol_evt,
    input  logic ovf_evt,
    output logic track_en,
    output logic clr_all,
    output logic violation,
    output logic overflow,
    output logic rollback_req
);
    lb_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LB_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = LB_IDLE;
        end else begin
            unique case (state_q)
                LB_IDLE, LB_TRACK: begin
                    if (viol_evt)                         state_d = LB_VIOLATED;
                    else if (ovf_evt)                     state_d = LB_OVERFLOWED;
                    else if (miss_mode)                   state_d = LB_TRACK;
                    else                                  state_d = LB_IDLE;
                end
                LB_VIOLATED:   state_d = LB_VIOLATED;
                LB_OVERFLOWED: state_d = LB_OVERFLOWED;
                default:       state_d = LB_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        track_en     = 1'b0;
        clr_all      = clear;
        violation    = 1'b0;
        overflow     = 1'b0;
        rollback_req = 1'b0;
        unique case (state_q)
            LB_IDLE: begin
                track_en = miss_mode && !clear;
            end
            LB_TRACK: begin
                track_en = miss_mode && !clear;
                clr_all  = clear || !miss_mode;
            end
            LB_VIOLATED: begin
                violation    = 1'b1;
                rollback_req = 1'b1;
            end
            LB_OVERFLOWED: begin
                overflow     = 1'b1;
                rollback_req = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lb_victim_pick.sv
module lb_victim_pick #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  free_ways,
    input  logic [WAY_W-1:0] start,
    output logic             any_free,
    output logic [WAY_W-1:0] pick
);
    // first free way at or after start, wrapping (WAYS is a power of two)
    always_comb begin
        any_free = |free_ways;
        pick     = start;
        for (int k = WAYS - 1; k >= 0; k--) begin
            logic [WAY_W-1:0] cand;
            cand = start + WAY_W'(k);
            if (free_ways[cand]) pick = cand;
        end
    end
endmodule

// File: rtl/lb_set_array.sv
module lb_set_array #(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int TAG_W = 20,
    parameter int AGE_W = 8,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_all,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_set,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic [AGE_W-1:0]            wr_age,
    input  logic [IDX_W-1:0]            a_set,
    output logic [WAYS-1:0]             a_valid,
    output logic [WAYS-1:0][TAG_W-1:0]  a_tag,
    output logic [WAYS-1:0][AGE_W-1:0]  a_age,
    input  logic [IDX_W-1:0]            b_set,
    output logic [WAYS-1:0]             b_valid,
    output logic [WAYS-1:0][TAG_W-1:0]  b_tag,
    output logic [WAYS-1:0][AGE_W-1:0]  b_age
);
    logic [SETS-1:0][WAYS-1:0] valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       valid_q <= '0;
        else if (clr_all) valid_q <= '0;
        else if (wr_en)   valid_q[wr_set][wr_way] <= 1'b1;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        logic [AGE_W-1:0] age_q [SETS];

        always_ff @(posedge clk) begin
            if (wr_en && !clr_all && wr_way == WAY_W'(w)) begin
                tag_q[wr_set] <= wr_tag;
                age_q[wr_set] <= wr_age;
            end
        end

        always_comb begin
            a_tag[w] = tag_q[a_set];
            a_age[w] = age_q[a_set];
            b_tag[w] = tag_q[b_set];
            b_age[w] = age_q[b_set];
        end
    end

    assign a_valid = valid_q[a_set];
    assign b_valid = valid_q[b_set];
endmodule

// File: rtl/unordered_load_buffer.sv
module unordered_load_buffer #(
    parameter int ADDR_W     = 32,
    parameter int LINE_OFF_W = 6,
    parameter int SETS       = 64,
    parameter int WAYS       = 4,
    parameter int AGE_W      = 8,
    localparam int IDX_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS),
    localparam int LINE_W    = ADDR_W - LINE_OFF_W,
    localparam int TAG_W     = LINE_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_mode,
    input  logic              clear,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [AGE_W-1:0]  ld_age,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [AGE_W-1:0]  st_age,
    output logic              violation,
    output logic              overflow,
    output logic              rollback_req
);
    // modular age order: a is younger than b
    function automatic logic is_younger(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
        logic [AGE_W-1:0] d;
        d = a - b;
        return (d != '0) && !d[AGE_W-1];
    endfunction

    logic [LINE_W-1:0] ld_line, st_line;
    logic [IDX_W-1:0]  ld_set, st_set;
    logic [TAG_W-1:0]  ld_tag, st_tag;

    assign ld_line = ld_addr[ADDR_W-1:LINE_OFF_W];
    assign st_line = st_addr[ADDR_W-1:LINE_OFF_W];
    assign ld_set  = ld_line[IDX_W-1:0];
    assign st_set  = st_line[IDX_W-1:0];
    assign ld_tag  = ld_line[LINE_W-1:IDX_W];
    assign st_tag  = st_line[LINE_W-1:IDX_W];

    logic track_en, clr_all, viol_evt, ovf_evt;

    // array read ports
    logic [WAYS-1:0]            ld_row_v, st_row_v;
    logic [WAYS-1:0][TAG_W-1:0] ld_row_t, st_row_t;
    logic [WAYS-1:0][AGE_W-1:0] ld_row_a, st_row_a;

    logic             wr_en;
    logic [WAY_W-1:0] wr_way;
    logic [AGE_W-1:0] wr_age;

    lb_set_array #(
        .SETS (SETS),
        .WAYS (WAYS),
        .TAG_W(TAG_W),
        .AGE_W(AGE_W)
    ) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_all(clr_all),
        .wr_en  (wr_en),
        .wr_set (ld_set),
        .wr_way (wr_way),
        .wr_tag (ld_tag),
        .wr_age (wr_age),
        .a_set  (ld_set),
        .a_valid(ld_row_v),
        .a_tag  (ld_row_t),
        .a_age  (ld_row_a),
        .b_set  (st_set),
        .b_valid(st_row_v),
        .b_tag  (st_row_t),
        .b_age  (st_row_a)
    );

    // insertion side: tag match per way
    logic [WAYS-1:0]  ld_hit;
    logic             ld_any_hit;
    logic [WAY_W-1:0] ld_hit_way;
    logic [AGE_W-1:0] ld_hit_age;

    for (genvar w = 0; w < WAYS; w++) begin : g_ldcmp
        assign ld_hit[w] = ld_row_v[w] && (ld_row_t[w] == ld_tag);
    end

    always_comb begin
        ld_any_hit = |ld_hit;
        ld_hit_way = '0;
        ld_hit_age = ld_row_a[0];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (ld_hit[w]) begin
                ld_hit_way = WAY_W'(w);
                ld_hit_age = ld_row_a[w];
            end
        end
    end

    // round-robin pointer per set
    logic [WAY_W-1:0] rr_q [SETS];
    logic             any_free;
    logic [WAY_W-1:0] victim;

    lb_victim_pick #(
        .WAYS (WAYS),
        .WAY_W(WAY_W)
    ) u_pick (
        .free_ways(~ld_row_v),
        .start    (rr_q[ld_set]),
        .any_free (any_free),
        .pick     (victim)
    );

    logic ld_acc;
    assign ld_acc = track_en && ld_valid;

    always_comb begin
        wr_en   = 1'b0;
        wr_way  = victim;
        wr_age  = ld_age;
        ovf_evt = 1'b0;
        if (ld_acc) begin
            if (ld_any_hit) begin
                wr_en  = 1'b1;
                wr_way = ld_hit_way;
                wr_age = is_younger(ld_age, ld_hit_age) ? ld_age : ld_hit_age;
            end else if (any_free) begin
                wr_en  = 1'b1;
                wr_way = victim;
            end else begin
                ovf_evt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (ld_acc && !ld_any_hit && any_free) begin
            rr_q[ld_set] <= victim + WAY_W'(1);
        end
    end

    // snoop side: indexed lookup of the store's set only
    logic [WAYS-1:0] st_hit;
    logic            st_bypass;

    for (genvar w = 0; w < WAYS; w++) begin : g_stcmp
        assign st_hit[w] = st_row_v[w] && (st_row_t[w] == st_tag)
                           && is_younger(st_row_a[w], st_age);
    end

    assign st_bypass = ld_acc && (ld_line == st_line) && is_younger(ld_age, st_age);
    assign viol_evt  = track_en && st_valid && ((|st_hit) || st_bypass);

    lb_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .miss_mode   (miss_mode),
        .clear       (clear),
        .viol_evt    (viol_evt),
        .ovf_evt     (ovf_evt),
        .track_en    (track_en),
        .clr_all     (clr_all),
        .violation   (violation),
        .overflow    (overflow),
        .rollback_req(rollback_req)
    );
endmodule

// File: rtl/lb_checker.sv
module lb_checker (
    input logic clk,
    input logic rst_n,
    input logic miss_mode,
    input logic clear,
    input logic ld_valid,
    input logic st_valid,
    input logic violation,
    input logic overflow,
    input logic rollback_req
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!violation && !overflow && !rollback_req));

    assert_idle_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_mode && !rollback_req) |=> !rollback_req);

    assert_viol_from_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(violation) |-> $past(st_valid && miss_mode && !clear));

    assert_ovf_from_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(ld_valid && miss_mode && !clear));

    assert_single_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(violation && overflow));

    assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && !clear) |=> violation);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clear) |=> overflow);

    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!violation && !overflow && !rollback_req));
endmodule

bind unordered_load_buffer lb_checker u_lb_checker (.*);

// File: tb/unordered_load_buffer_test.sv
module unordered_load_buffer_test;
    localparam int AW = 16;
    localparam int OW = 4;
    localparam int NS = 8;
    localparam int NW = 4;
    localparam int GW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_mode = 1'b0, clear = 1'b0;
    logic          ld_valid = 1'b0, st_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0, st_addr = '0;
    logic [GW-1:0] ld_age = '0, st_age = '0;
    logic          violation, overflow, rollback_req;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    unordered_load_buffer #(.ADDR_W(AW), .LINE_OFF_W(OW), .SETS(NS), .WAYS(NW), .AGE_W(GW)) uut (
        .clk(clk), .rst_n(rst_n), .miss_mode(miss_mode), .clear(clear),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_age(ld_age),
        .st_valid(st_valid), .st_addr(st_addr), .st_age(st_age),
        .violation(violation), .overflow(overflow), .rollback_req(rollback_req));

    function automatic logic [AW-1:0] mk(input int tag, input int set, input int off);
        return {tag[8:0], set[2:0], off[3:0]};
    endfunction

    function automatic logic younger(input int l, input int s);
        int d;
        d = (l - s) & 15;
        return (d != 0) && (d < 8);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req, input logic v, input logic o);
        chk({req, " violation"}, violation, v);
        chk({req, " overflow"}, overflow, o);
        chk({req, " rollback_req"}, rollback_req, v | o);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
        st_valid = 1'b0;
        clear    = 1'b0;
    endtask

    task automatic do_clear();
        clear = 1'b1;
        cyc();
    endtask

    task automatic do_ld(input logic [AW-1:0] a, input int g);
        ld_valid = 1'b1; ld_addr = a; ld_age = g[GW-1:0];
        cyc();
    endtask

    task automatic do_st(input logic [AW-1:0] a, input int g);
        st_valid = 1'b1; st_addr = a; st_age = g[GW-1:0];
        cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_flags("R1 in reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_flags("R1 after reset", 1'b0, 1'b0);

        // R3: nothing recorded or flagged while miss_mode is low
        ld_valid = 1; ld_addr = mk(3, 1, 0); ld_age = 4'd5;
        st_valid = 1; st_addr = mk(3, 1, 0); st_age = 4'd1;
        cyc();
        chk_flags("R3 idle same-cycle", 1'b0, 1'b0);
        do_ld(mk(3, 1, 0), 5);
        miss_mode = 1'b1;
        do_st(mk(3, 1, 0), 1);
        chk_flags("R3 idle load not recorded", 1'b0, 1'b0);

        // R4 / R5: every pair of ages
        for (int l = 0; l < 16; l++) begin
            for (int s = 0; s < 16; s++) begin
                do_clear();
                do_ld(mk(l + 1, l % NS, 2), l);
                do_st(mk(l + 1, l % NS, 9), s);
                chk("R4 age sweep violation", violation, younger(l, s));
                do_clear();
                ld_valid = 1; ld_addr = mk(s + 2, s % NS, 0); ld_age = l[GW-1:0];
                st_valid = 1; st_addr = mk(s + 2, s % NS, 15); st_age = s[GW-1:0];
                cyc();
                chk("R5 same-cycle violation", violation, younger(l, s));
            end
        end

        // R2: set and tag decode
        do_clear();
        do_ld(mk(7, 2, 3), 6);
        do_st(mk(8, 2, 3), 2);
        chk_flags("R2 other tag same set", 1'b0, 1'b0);
        do_st(mk(7, 3, 3), 2);
        chk_flags("R2 same tag other set", 1'b0, 1'b0);
        do_st(mk(7, 2, 12), 2);
        chk_flags("R2 same line other offset", 1'b1, 1'b0);

        // R7: fill every set
        for (int s = 0; s < NS; s++) begin
            do_clear();
            for (int t = 0; t < NW; t++) do_ld(mk(t + 1, s, 0), 3);
            chk_flags("R7 set full no overflow", 1'b0, 1'b0);
            do_ld(mk(NW + 1, s, 0), 3);
            chk_flags("R7 extra line overflows", 1'b0, 1'b1);
        end

        // R6: repeated line takes one way and keeps younger age
        do_clear();
        for (int k = 0; k < NW + 2; k++) do_ld(mk(1, 5, k), 3);
        for (int t = 2; t <= NW; t++) do_ld(mk(t, 5, 0), 0);
        chk_flags("R6 merged loads no overflow", 1'b0, 1'b0);
        do_ld(mk(1, 5, 0), 1);
        do_st(mk(1, 5, 0), 2);
        chk_flags("R6 younger age kept", 1'b1, 1'b0);

        // R8: simultaneous causes report violation only
        do_clear();
        for (int t = 1; t <= NW; t++) do_ld(mk(t, 0, 0), 9);
        ld_valid = 1; ld_addr = mk(NW + 1, 0, 0); ld_age = 4'd9;
        st_valid = 1; st_addr = mk(1, 0, 0); st_age = 4'd2;
        cyc();
        chk_flags("R8 violation wins", 1'b1, 1'b0);

        // R9: sticky through miss_mode drop and traffic
        miss_mode = 1'b0;
        cyc(); cyc();
        chk_flags("R9 hold miss_mode low", 1'b1, 1'b0);
        miss_mode = 1'b1;
        do_ld(mk(9, 4, 0), 1);
        chk_flags("R9 hold under traffic", 1'b1, 1'b0);
        do_clear();
        chk_flags("R10 clear drops flag", 1'b0, 1'b0);
        for (int t = 1; t <= NW + 1; t++) do_ld(mk(t, 6, 0), 0);
        chk_flags("R9 overflow set", 1'b0, 1'b1);
        do_st(mk(1, 6, 0), 15);
        chk_flags("R9 overflow held, store ignored", 1'b0, 1'b1);

        // R10: clear beats same-cycle store, entries gone
        do_clear();
        do_ld(mk(4, 7, 0), 5);
        clear = 1; st_valid = 1; st_addr = mk(4, 7, 0); st_age = 4'd1;
        cyc();
        chk_flags("R10 clear beats store", 1'b0, 1'b0);
        do_st(mk(4, 7, 0), 1);
        chk_flags("R10 entries invalidated", 1'b0, 1'b0);

        // R11: miss window end invalidates
        do_clear();
        do_ld(mk(5, 3, 0), 5);
        miss_mode = 1'b0;
        cyc();
        miss_mode = 1'b1;
        do_st(mk(5, 3, 0), 1);
        chk_flags("R11 window end invalidates", 1'b0, 1'b0);
        do_ld(mk(5, 3, 0), 5);
        do_st(mk(5, 3, 0), 1);
        chk_flags("R11 tracking resumes", 1'b1, 1'b0);

        finish_run();
    end
endmodule